// File: doc/BRIEF.md
# Turbo Code Block Rate Matcher

This block turns the three coded streams of one turbo code block (the systematic stream and two parity streams, each D bits long) into a serial burst of exactly E bits for transmission. Each stream is written into an internal bit store through a simple load port. A start pulse then supplies the stream length D, the burst length E and a starting offset k0. From these the block walks a virtual circular buffer that is never stored. The buffer holds the interleaved systematic stream first, followed by the two interleaved parity streams taken one bit at a time in alternation.

Each stream is reordered by a 32-column block interleaver with R = ceil(D/32) rows. The matrix is filled row by row, with 32R − D filler (dummy) entries placed ahead of the data. It is read column by column, with the columns visited in bit-reversed order. Selection starts at buffer entry k0, skips filler entries and wraps from the last entry back to entry 0 until E bits have been sent. Bits leave one per cycle with a valid strobe. A filler entry costs one cycle and produces no valid bit.

Top module: `rm_rate_match`

## Requirements
- R1: After reset, busy, out_valid and done are all 0.
- R2: A start pulse while idle with e_len > 0 sets busy. The block then emits exactly e_len bits with out_valid. done is high for one cycle, in the same cycle as the last valid bit, and busy is 0 from that cycle on.
- R3: The circular buffer has 96R entries. Entries 0..32R−1 are the interleaved systematic stream (ld_sel 0). Entries 32R+2k and 32R+2k+1 are interleaved entry k of parity 1 (ld_sel 1) and of parity 2 (ld_sel 2).
- R4: For the systematic and parity-1 streams, interleaved entry k reads matrix position 32·(k mod R) + rev5(floor(k/R)), where rev5 reverses a 5-bit column number. Matrix positions below ND = 32R − D are filler. Position ND+i holds stream bit i, which is loaded at ld_addr i.
- R5: For the parity-2 stream, interleaved entry k reads matrix position (32·(k mod R) + rev5(floor(k/R)) + 1) mod 32R, with the same filler rule.
- R6: Filler entries produce no output bit. Every emitted bit comes from a non-filler entry.
- R7: Selection begins at entry k0 (k0 < 96R). After entry 96R−1 it continues at entry 0, and it may wrap as often as needed.
- R8: A start with e_len = 0 produces a done pulse on the next cycle, emits no bit and leaves busy at 0.
- R9: While busy, start pulses and load writes are ignored. The running burst and the stored stream bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one stream bit (idle only) |
| ld_sel | input | 2 | Stream select: 0 systematic, 1 parity 1, 2 parity 2 |
| ld_addr | input | 7 | Bit index within the stream |
| ld_bit | input | 1 | Bit value to write |
| start | input | 1 | Begin a burst (idle only) |
| d_len | input | 8 | Stream length D, 1..128 |
| e_len | input | 14 | Number of bits to emit |
| k0 | input | 9 | Starting buffer entry, below 96R |
| busy | output | 1 | A burst is in progress |
| out_valid | output | 1 | out_bit carries a selected bit |
| out_bit | output | 1 | Selected bit |
| done | output | 1 | One-cycle pulse with the last bit |

## Verification
The assertions check several properties on every cycle. The emitted count never reaches e_len while the burst is still emitting. A valid bit only follows a cycle spent emitting. A filler entry never yields a valid bit. done lasts a single cycle. The seek phase hands over to emission at the right time. The interleaver row and the shifted parity-2 position stay inside the matrix. A start while busy leaves the latched burst parameters alone. Only the bench scenarios can show that the bit values and their order match the interleaver, collection and wraparound rules. These scenarios cover heavy filler with D = 1, no filler with D = 128, mid-buffer offsets, multiple wraps, e_len = 0, and ignored starts and writes during a burst.

// File: rtl/rm_pkg.sv
package rm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEEK = 2'd1,
        ST_EMIT = 2'd2
    } rm_state_e;

    // Column visiting order of the 32-column interleaver: 5-bit reversal.
    function automatic logic [4:0] col_perm(input logic [4:0] c);
        return {c[0], c[1], c[2], c[3], c[4]};
    endfunction

endpackage

// File: rtl/rm_store.sv
module rm_store #(
    parameter int MAX_D = 128,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [1:0]    rd_sel,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);

    logic [MAX_D-1:0] bits_q [3];

    for (genvar s = 0; s < 3; s++) begin : g_stream
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q[s] <= '0;
            end else if (wr_en && (wr_sel == 2'(s)) && (int'(wr_addr) < MAX_D)) begin
                bits_q[s][wr_addr] <= wr_bit;
            end
        end
    end

    always_comb begin
        rd_bit = 1'b0;
        if (int'(rd_addr) < MAX_D) begin
            case (rd_sel)
                2'd0:    rd_bit = bits_q[0][rd_addr];
                2'd1:    rd_bit = bits_q[1][rd_addr];
                2'd2:    rd_bit = bits_q[2][rd_addr];
                default: rd_bit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/rm_walker.sv
module rm_walker
    import rm_pkg::*;
#(
    parameter int ROW_W = 2,
    parameter int PX_W  = ROW_W + 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic            step,
    input  logic [ROW_W:0]  r_len,
    output logic [1:0]      strm,
    output logic [PX_W-1:0] pos_ext
);

    typedef struct packed {
        logic             par;
        logic             half;
        logic [4:0]       col;
        logic [ROW_W-1:0] row;
    } walk_t;

    walk_t w_d, w_q;
    logic [PX_W-1:0] base, kpi, p2pos;
    logic            last_row;

    assign last_row = ({1'b0, w_q.row} == (r_len - 1'b1));

    always_comb begin
        w_d = w_q;
        if (init) begin
            w_d = '0;
        end else if (step) begin
            if (w_q.par && !w_q.half) begin
                w_d.half = 1'b1;
            end else begin
                w_d.half = 1'b0;
                if (last_row) begin
                    w_d.row = '0;
                    if (w_q.col == 5'd31) begin
                        w_d.col = '0;
                        w_d.par = ~w_q.par;
                    end else begin
                        w_d.col = w_q.col + 5'd1;
                    end
                end else begin
                    w_d.row = w_q.row + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    always_comb begin
        base  = {1'b0, w_q.row, 5'b0} + PX_W'(col_perm(w_q.col));
        kpi   = {r_len, 5'b0};
        p2pos = base + 1'b1;
        if (p2pos == kpi) p2pos = '0;
        strm    = w_q.par ? (w_q.half ? 2'd2 : 2'd1) : 2'd0;
        pos_ext = (w_q.par && w_q.half) ? p2pos : base;
    end

    assert_row_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ({1'b0, w_q.row} < r_len));

    assert_p2_pos_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && strm == 2'd2) |-> (pos_ext < kpi));

    assert_half_in_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !w_q.par) |-> !w_q.half);

endmodule

// File: rtl/rm_rate_match.sv
module rm_rate_match
    import rm_pkg::*;
#(
    parameter int MAX_D = 128,
    parameter int E_W   = 14
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ld_en,
    input  logic [1:0]                      ld_sel,
    input  logic [$clog2(MAX_D)-1:0]        ld_addr,
    input  logic                            ld_bit,
    input  logic                            start,
    input  logic [$clog2(MAX_D+1)-1:0]      d_len,
    input  logic [E_W-1:0]                  e_len,
    input  logic [$clog2(96*((MAX_D+31)/32))-1:0] k0,
    output logic                            busy,
    output logic                            out_valid,
    output logic                            out_bit,
    output logic                            done
);

    localparam int MAX_R = (MAX_D + 31) / 32;
    localparam int ROW_W = (MAX_R > 1) ? $clog2(MAX_R) : 1;
    localparam int PX_W  = ROW_W + 6;
    localparam int AW    = $clog2(MAX_D);
    localparam int DL_W  = $clog2(MAX_D + 1);
    localparam int K0_W  = $clog2(96 * MAX_R);

    typedef struct packed {
        rm_state_e       state;
        logic [E_W-1:0]  e_len;
        logic [E_W-1:0]  cnt;
        logic [K0_W-1:0] seek;
        logic [ROW_W:0]  r_len;
        logic [PX_W-1:0] nd;
        logic            out_valid;
        logic            out_bit;
        logic            done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic            walk_init, walk_step;
    logic [1:0]      strm;
    logic [PX_W-1:0] pos_ext;
    logic            is_dummy;
    logic [AW-1:0]   rd_addr;
    logic            rd_bit;
    logic            idle;
    logic [DL_W+1:0] r_calc;
    logic [ROW_W:0]  r_new;

    assign idle     = (ctl_q.state == ST_IDLE);
    assign is_dummy = (pos_ext < ctl_q.nd);
    assign rd_addr  = AW'(pos_ext - ctl_q.nd);
    assign r_calc   = ({2'b0, d_len} + (DL_W+2)'(31)) >> 5;
    assign r_new    = r_calc[ROW_W:0];

    rm_store #(.MAX_D(MAX_D), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ld_en && idle),
        .wr_sel  (ld_sel),
        .wr_addr (ld_addr),
        .wr_bit  (ld_bit),
        .rd_sel  (strm),
        .rd_addr (rd_addr),
        .rd_bit  (rd_bit)
    );

    rm_walker #(.ROW_W(ROW_W), .PX_W(PX_W)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (walk_init),
        .step    (walk_step),
        .r_len   (ctl_q.r_len),
        .strm    (strm),
        .pos_ext (pos_ext)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.out_valid = 1'b0;
        ctl_d.out_bit   = 1'b0;
        ctl_d.done      = 1'b0;
        walk_init       = 1'b0;
        walk_step       = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (e_len == '0) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.state = ST_SEEK;
                        ctl_d.e_len = e_len;
                        ctl_d.cnt   = '0;
                        ctl_d.seek  = k0;
                        ctl_d.r_len = r_new;
                        ctl_d.nd    = {r_new, 5'b0} - PX_W'(d_len);
                        walk_init   = 1'b1;
                    end
                end
            end
            ST_SEEK: begin
                if (ctl_q.seek == '0) begin
                    ctl_d.state = ST_EMIT;
                end else begin
                    walk_step  = 1'b1;
                    ctl_d.seek = ctl_q.seek - 1'b1;
                end
            end
            ST_EMIT: begin
                walk_step = 1'b1;
                if (!is_dummy) begin
                    ctl_d.out_valid = 1'b1;
                    ctl_d.out_bit   = rd_bit;
                    ctl_d.cnt       = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt + 1'b1 == ctl_q.e_len) begin
                        ctl_d.done  = 1'b1;
                        ctl_d.state = ST_IDLE;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy      = !idle;
    assign out_valid = ctl_q.out_valid;
    assign out_bit   = ctl_q.out_bit;
    assign done      = ctl_q.done;

    assert_emit_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_EMIT) |-> (ctl_q.cnt < ctl_q.e_len));

    assert_valid_after_emit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(ctl_q.state) == ST_EMIT));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy) |-> 1'b0);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    assert_dummy_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_EMIT && is_dummy) |=> !out_valid);

    assert_seek_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_SEEK && ctl_q.seek == '0) |=> (ctl_q.state == ST_EMIT));

    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(ctl_q.e_len));

endmodule

// File: tb/rm_rate_match_tb.sv
module rm_rate_match_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_en = 1'b0;
    logic [1:0] ld_sel = '0;
    logic [6:0] ld_addr = '0;
    logic       ld_bit = 1'b0;
    logic       start = 1'b0;
    logic [7:0] d_len = '0;
    logic [13:0] e_len = '0;
    logic [8:0] k0 = '0;
    logic       busy, out_valid, out_bit, done;

    int checks = 0;
    int fails  = 0;
    bit model [3][128];
    bit exp_q [$];
    int got_cnt = 0;
    int exp_e = 0;
    bit seen_done = 1'b0;
    bit mon_on = 1'b0;

    always #5 clk = ~clk;

    rm_rate_match u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
        .ld_bit(ld_bit), .start(start), .d_len(d_len), .e_len(e_len), .k0(k0),
        .busy(busy), .out_valid(out_valid), .out_bit(out_bit), .done(done)
    );

    function automatic int rev5(input int c);
        int r = 0;
        for (int b = 0; b < 5; b++) if (c & (1 << b)) r |= 1 << (4 - b);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Reference: R3 layout, R4/R5 positions, R6 filler skip, R7 wrap.
    task automatic build_expected(input int d, input int e, input int s0);
        int r, kpi, nd, j, ent, k, pos, st;
        r = (d + 31) / 32; kpi = 32 * r; nd = kpi - d;
        exp_q.delete();
        j = s0;
        while (exp_q.size() < e) begin
            if (j < kpi) begin
                k = j; st = 0;
            end else begin
                ent = j - kpi; k = ent / 2; st = 1 + (ent % 2);
            end
            pos = rev5(k / r) + 32 * (k % r);
            if (st == 2) pos = (pos + 1) % kpi;
            if (pos >= nd) exp_q.push_back(model[st][pos - nd]);
            j = (j + 1) % (3 * kpi);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on && out_valid) begin
            got_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 extra bit", got_cnt, exp_e);
            end else begin
                bit eb;
                eb = exp_q.pop_front();
                check(out_bit == eb, "R4/R5/R7 bit value", int'(out_bit), int'(eb));
            end
        end
        if (mon_on && done) begin
            seen_done = 1'b1;
            check(got_cnt == exp_e, "R2 bit count at done", got_cnt, exp_e);
            check(busy == 1'b0, "R2 busy after done", int'(busy), 0);
        end
    end

    task automatic load_stream(input int d, input int seed);
        for (int s = 0; s < 3; s++) begin
            for (int i = 0; i < d; i++) begin
                @(posedge clk); #1;
                ld_en = 1'b1; ld_sel = 2'(s); ld_addr = 7'(i);
                ld_bit = ((i * 7 + s * 13 + seed) % 5) < 2;
                model[s][i] = ld_bit;
            end
        end
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic pulse_start(input int d, input int e, input int s0);
        @(posedge clk); #1;
        d_len = 8'(d); e_len = 14'(e); k0 = 9'(s0); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!seen_done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input int d, input int e, input int s0, input string tag);
        build_expected(d, e, s0);
        exp_e = e; got_cnt = 0; seen_done = 1'b0; mon_on = 1'b1;
        pulse_start(d, e, s0);
        if (e > 0) check(busy == 1'b1 || seen_done, {tag, " R2 busy after start"}, int'(busy), 1);
        wait_done();
        check(exp_q.size() == 0, {tag, " queue drained"}, exp_q.size(), 0);
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(busy == 0 && out_valid == 0 && done == 0, "R1 reset state",
              int'({busy, out_valid, done}), 0);
        rst_n = 1'b1;

        load_stream(40, 3);
        run(40, 100, 0, "R4 D=40 k0=0");
        run(40, 300, 200, "R7 D=40 wrap");

        load_stream(128, 1);
        run(128, 500, 300, "R3 D=128 no filler");

        load_stream(1, 0);
        run(1, 10, 5, "R6 D=1 heavy filler");

        load_stream(77, 2);
        run(77, 50, 95, "R5 D=77 mid offset");

        // R8: zero-length burst
        run(77, 0, 0, "R8 E=0");
        check(busy == 0, "R8 busy stays low", int'(busy), 0);

        // R9: start and load while busy are ignored
        build_expected(77, 200, 10);
        exp_e = 200; got_cnt = 0; seen_done = 1'b0; mon_on = 1'b1;
        pulse_start(77, 200, 10);
        repeat (20) @(posedge clk);
        #1;
        start = 1'b1; e_len = 14'd3; k0 = 9'd0;
        ld_en = 1'b1; ld_sel = 2'd0; ld_addr = 7'd5; ld_bit = ~model[0][5];
        @(posedge clk); #1;
        start = 1'b0; ld_en = 1'b0;
        wait_done();
        check(exp_q.size() == 0, "R9 burst unaffected", exp_q.size(), 0);
        mon_on = 1'b0;
        run(77, 120, 0, "R9 stored bits unchanged");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule